// File: doc/BRIEF.md
# Serial Link Start-Up and Recovery Controller

This block sequences a full-duplex, point-to-point serial link from power-up to traffic and back again after a fault. It consumes one-cycle event flags raised by the character receiver, plus a report from the transmitter that a NULL has gone out. From these it decides when the receiver may run and what class of characters the transmitter may emit. A silent recovery period comes first, so that the far end notices the loss of activity. A NULL exchange follows, then an FCT exchange, and only after those is general traffic allowed.

Both recovery intervals (6.4 µs and 12.8 µs) are counted by one shared counter. Its limits are worked out at elaboration from a system clock frequency parameter given in kHz. With the default of 100 MHz the limits are 640 and 1280 cycles. Any fault detected while the link is coming up or carrying traffic sends the controller back to the silent state. That return clears the record of NULLs seen and sent, so every restart runs the whole sequence again.

Top module: `lnk_init_ctrl`

## Requirements
- R1: While `rst_n` is low, `rx_en`=0, `tx_mode`=00 and `link_up`=0. After `rst_n` goes high, this quiet state holds for exactly SHORT = CLK_KHZ*64/10000 clock edges, and then `rx_en` goes to 1.
- R2: Once `rx_en` has risen, `tx_mode` stays 00 for LONG = CLK_KHZ*128/10000 edges whatever NULLs arrive, and then the controller becomes idle. If `link_en` is already high, `tx_mode` is 01 after edge LONG+1.
- R3: While idle, the controller keeps `tx_mode`=00 for as long as `link_en` is low. One edge after `link_en` is seen high it enters the announce phase, in which `tx_mode`=01 (NULLs only).
- R4: The announce phase moves to the handshake phase (`tx_mode`=10, FCTs and NULLs) on the first edge at which a NULL has been received and a NULL has been sent (`tx_null_done`). A NULL received earlier during recovery or idle counts toward this.
- R5: If the announce phase does not complete, the controller returns to the quiet state (`rx_en`=0, `tx_mode`=00) LONG edges after entering it.
- R6: In the handshake phase, `rx_fct` moves the controller to the active phase (`tx_mode`=11, `link_up`=1). Without `rx_fct`, it falls back to the quiet state LONG edges after entry. `link_up` is 1 only in the active phase.
- R7: During recovery, idle and announce, `rx_disc` always forces the quiet state. `rx_par_err`, `rx_esc_err`, `rx_fct` and `rx_nchar` force it only once a NULL has been recorded; before that they are ignored.
- R8: In the handshake phase, `rx_disc`, `rx_par_err`, `rx_esc_err` or `rx_nchar` forces the quiet state.
- R9: In the active phase, `link_en` low, `rx_disc`, `rx_par_err`, `rx_esc_err` or `credit_err` forces the quiet state. `credit_err` has no effect in any other phase.
- R10: When a fault and a forward step (handshake completion or `rx_fct`) fall in the same cycle, the fault wins. When a forward step and the end of a phase timeout fall in the same cycle, the forward step wins.
- R11: Entering the quiet state forgets any NULL recorded earlier. After a restart, a parity error in recovery is ignored until a new NULL arrives.
- R12: Both timer limits are computed from `CLK_KHZ`. The quiet state runs for SHORT cycles, and the recovery, announce and handshake timeouts run for LONG cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Permission to start and keep the link |
| rx_null | input | 1 | Receiver decoded a NULL this cycle |
| rx_fct | input | 1 | Receiver decoded an FCT this cycle |
| rx_nchar | input | 1 | Receiver decoded a data, end-of-packet or time-code character |
| rx_disc | input | 1 | Receiver detected loss of line activity |
| rx_par_err | input | 1 | Receiver parity error |
| rx_esc_err | input | 1 | Receiver illegal escape sequence |
| credit_err | input | 1 | Flow-control credit violation |
| tx_null_done | input | 1 | Transmitter finished sending a NULL |
| rx_en | output | 1 | Receiver enable (0 holds it in reset) |
| tx_mode | output | 2 | 00 reset, 01 NULLs only, 10 FCTs and NULLs, 11 all characters |
| link_up | output | 1 | High only in the active phase |

## Verification
Two situations in this controller involve two things in the same cycle. In the first, a fault arrives on the same edge as a forward step: the bench raises `rx_fct` together with `rx_par_err` in the handshake phase and expects the quiet state, not the active phase. In the second, the handshake completes on the very cycle the announce timeout expires: the bench counts the cycles since the phase was entered and raises `rx_null` and `tx_null_done` on the last counted cycle. It then expects `tx_mode`=10 and not a fall to reset. A vector table also drives each fault flag into every phase, both before and after a NULL has been recorded, and compares `rx_en` and `tx_mode` one cycle later.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic [2:0] {
        ST_QUIESCE   = 3'd0,
        ST_LISTEN    = 3'd1,
        ST_IDLE      = 3'd2,
        ST_ANNOUNCE  = 3'd3,
        ST_HANDSHAKE = 3'd4,
        ST_ACTIVE    = 3'd5
    } lnk_state_e;

    typedef enum logic [1:0] {
        TXM_OFF  = 2'b00,
        TXM_NULL = 2'b01,
        TXM_FCT  = 2'b10,
        TXM_ALL  = 2'b11
    } tx_mode_e;

    typedef struct packed {
        lnk_state_e state;
        logic       null_seen;
        logic       null_sent;
    } ctl_t;

endpackage

// File: rtl/lnk_interval_timer.sv
module lnk_interval_timer #(
    parameter int unsigned SHORT_CYC = 640,
    parameter int unsigned LONG_CYC  = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_hit,
    output logic long_hit
);
    localparam int unsigned CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)
            cnt_d = '0;
        else if (cnt_q == LONG_LAST)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign short_hit = (cnt_q == SHORT_LAST);
    assign long_hit  = (cnt_q == LONG_LAST);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LONG_LAST && !restart) |=> (cnt_q == LONG_LAST));

endmodule

// File: rtl/lnk_fault_detect.sv
module lnk_fault_detect
    import lnk_pkg::*;
(
    input  lnk_state_e state,
    input  logic       null_seen,
    input  logic       link_en,
    input  logic       rx_fct,
    input  logic       rx_nchar,
    input  logic       rx_disc,
    input  logic       rx_par_err,
    input  logic       rx_esc_err,
    input  logic       credit_err,
    output logic       fault
);
    logic line_err;

    always_comb begin
        line_err = rx_disc | rx_par_err | rx_esc_err;
        unique case (state)
            ST_LISTEN, ST_IDLE, ST_ANNOUNCE:
                fault = rx_disc |
                        (null_seen & (rx_par_err | rx_esc_err | rx_fct | rx_nchar));
            ST_HANDSHAKE:
                fault = line_err | rx_nchar;
            ST_ACTIVE:
                fault = line_err | credit_err | !link_en;
            default:
                fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/lnk_init_ctrl.sv
module lnk_init_ctrl
    import lnk_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_en,
    input  logic       rx_null,
    input  logic       rx_fct,
    input  logic       rx_nchar,
    input  logic       rx_disc,
    input  logic       rx_par_err,
    input  logic       rx_esc_err,
    input  logic       credit_err,
    input  logic       tx_null_done,
    output logic       rx_en,
    output logic [1:0] tx_mode,
    output logic       link_up
);
    // 6.4 us and 12.8 us expressed in clock cycles
    localparam int unsigned SHORT_CYC = (CLK_KHZ * 64) / 10000;
    localparam int unsigned LONG_CYC  = (CLK_KHZ * 128) / 10000;

    ctl_t ctl_d, ctl_q;
    logic fault, short_hit, long_hit, restart, hs_done;

    lnk_fault_detect i_fault (
        .state      (ctl_q.state),
        .null_seen  (ctl_q.null_seen),
        .link_en    (link_en),
        .rx_fct     (rx_fct),
        .rx_nchar   (rx_nchar),
        .rx_disc    (rx_disc),
        .rx_par_err (rx_par_err),
        .rx_esc_err (rx_esc_err),
        .credit_err (credit_err),
        .fault      (fault)
    );

    lnk_interval_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .short_hit (short_hit),
        .long_hit  (long_hit)
    );

    always_comb begin
        ctl_d   = ctl_q;
        hs_done = (ctl_q.null_seen | rx_null) & (ctl_q.null_sent | tx_null_done);

        unique case (ctl_q.state)
            ST_QUIESCE:   if (short_hit) ctl_d.state = ST_LISTEN;
            ST_LISTEN:    if (fault)          ctl_d.state = ST_QUIESCE;
                          else if (long_hit)  ctl_d.state = ST_IDLE;
            ST_IDLE:      if (fault)          ctl_d.state = ST_QUIESCE;
                          else if (link_en)   ctl_d.state = ST_ANNOUNCE;
            ST_ANNOUNCE:  if (fault)          ctl_d.state = ST_QUIESCE;
                          else if (hs_done)   ctl_d.state = ST_HANDSHAKE;
                          else if (long_hit)  ctl_d.state = ST_QUIESCE;
            ST_HANDSHAKE: if (fault)          ctl_d.state = ST_QUIESCE;
                          else if (rx_fct)    ctl_d.state = ST_ACTIVE;
                          else if (long_hit)  ctl_d.state = ST_QUIESCE;
            ST_ACTIVE:    if (fault)          ctl_d.state = ST_QUIESCE;
            default:      ctl_d.state = ST_QUIESCE;
        endcase

        if (ctl_q.state != ST_QUIESCE && rx_null)
            ctl_d.null_seen = 1'b1;
        if (ctl_q.state inside {ST_ANNOUNCE, ST_HANDSHAKE, ST_ACTIVE} && tx_null_done)
            ctl_d.null_sent = 1'b1;
        if (ctl_d.state == ST_QUIESCE) begin
            ctl_d.null_seen = 1'b0;
            ctl_d.null_sent = 1'b0;
        end

        restart = (ctl_d.state != ctl_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_QUIESCE;
            ctl_q.null_seen <= 1'b0;
            ctl_q.null_sent <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rx_en   = (ctl_q.state != ST_QUIESCE);
        link_up = (ctl_q.state == ST_ACTIVE);
        unique case (ctl_q.state)
            ST_ANNOUNCE:  tx_mode = TXM_NULL;
            ST_HANDSHAKE: tx_mode = TXM_FCT;
            ST_ACTIVE:    tx_mode = TXM_ALL;
            default:      tx_mode = TXM_OFF;
        endcase
    end

    // R1
    quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> (tx_mode == 2'b00));

    // R3
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'b01 && $past(tx_mode) == 2'b00) |-> $past(link_en));

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> ($past(tx_mode) == 2'b10 && $past(rx_fct)));

    // R7
    disc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_disc) |=> !rx_en);

    // R9
    run_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !link_en) |=> (!link_up && !rx_en));

endmodule

// File: tb/test_lnk_init_ctrl.sv
module test_lnk_init_ctrl;
    // 2.5 MHz nominal clock value: 6.4 us -> 16 cycles, 12.8 us -> 32 cycles
    localparam int unsigned CLK_KHZ = 2500;
    localparam int SHORT = 16;
    localparam int LONG  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_en = 1'b0;
    logic rx_null = 1'b0, rx_fct = 1'b0, rx_nchar = 1'b0, rx_disc = 1'b0;
    logic rx_par_err = 1'b0, rx_esc_err = 1'b0, credit_err = 1'b0, tx_null_done = 1'b0;
    logic rx_en, link_up;
    logic [1:0] tx_mode;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lnk_init_ctrl #(.CLK_KHZ(CLK_KHZ)) i_lnk_init_ctrl (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .rx_null(rx_null), .rx_fct(rx_fct), .rx_nchar(rx_nchar), .rx_disc(rx_disc),
        .rx_par_err(rx_par_err), .rx_esc_err(rx_esc_err), .credit_err(credit_err),
        .tx_null_done(tx_null_done),
        .rx_en(rx_en), .tx_mode(tx_mode), .link_up(link_up)
    );

    // vector: [10:8] phase (0 recovery,1 idle,2 announce,3 handshake,4 active),
    // [7] NULL recorded first, [6:1] {credit,esc,par,disc,nchar,fct}, [0] expect drop
    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 1'b0, 6'b001000, 1'b0},
        {3'd0, 1'b0, 6'b000100, 1'b1},
        {3'd0, 1'b1, 6'b001000, 1'b1},
        {3'd1, 1'b0, 6'b000010, 1'b0},
        {3'd1, 1'b1, 6'b000010, 1'b1},
        {3'd1, 1'b1, 6'b010000, 1'b1},
        {3'd2, 1'b0, 6'b000001, 1'b0},
        {3'd2, 1'b1, 6'b000001, 1'b1},
        {3'd2, 1'b0, 6'b100000, 1'b0},
        {3'd3, 1'b0, 6'b000010, 1'b1},
        {3'd3, 1'b0, 6'b001000, 1'b1},
        {3'd3, 1'b0, 6'b100000, 1'b0},
        {3'd4, 1'b0, 6'b100000, 1'b1},
        {3'd4, 1'b0, 6'b010000, 1'b1},
        {3'd4, 1'b0, 6'b000010, 1'b0},
        {3'd4, 1'b0, 6'b000100, 1'b1}
    };

    function automatic logic [1:0] mode_of(input int ph);
        case (ph)
            2: return 2'b01;
            3: return 2'b10;
            4: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_ev();
        rx_null = 0; rx_fct = 0; rx_nchar = 0; rx_disc = 0;
        rx_par_err = 0; rx_esc_err = 0; credit_err = 0; tx_null_done = 0;
    endtask

    // Reset, then walk to the given phase; returns at a negedge at the phase's first cycle
    task automatic goto(input int ph, input bit pre);
        rst_n = 0; link_en = 0; clear_ev();
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (SHORT) @(negedge clk);
        if (pre) begin rx_null = 1; @(negedge clk); rx_null = 0; end
        if (ph == 0) return;
        repeat (LONG - (pre ? 1 : 0)) @(negedge clk);
        if (ph == 1) return;
        link_en = 1; @(negedge clk);
        if (ph == 2) return;
        rx_null = 1; tx_null_done = 1; @(negedge clk); rx_null = 0; tx_null_done = 0;
        if (ph == 3) return;
        rx_fct = 1; @(negedge clk); rx_fct = 0;
    endtask

    function automatic int drop_state();
        return (rx_en == 1'b0 && tx_mode == 2'b00) ? 1 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        string tag;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "rx_en in reset", rx_en, 0);
        chk("R1", "tx_mode in reset", tx_mode, 0);
        chk("R1", "link_up in reset", link_up, 0);

        // R1 / R12 quiet duration after release
        rst_n = 1; n = 0;
        do begin @(negedge clk); n++; end while (!rx_en && n < 200);
        chk("R1", "quiet cycles", n, SHORT);

        // R2 / R12 recovery lasts LONG with NULLs arriving, link_en high throughout
        link_en = 1; n = 0;
        do begin
            rx_null = (n % 3 == 0);
            @(negedge clk); n++;
            rx_null = 0;
        end while (tx_mode == 2'b00 && n < 200);
        chk("R2", "recovery to announce cycles", n, LONG + 1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            int ph;
            ph = int'(VEC[i][10:8]);
            goto(ph, VEC[i][7]);
            {credit_err, rx_esc_err, rx_par_err, rx_disc, rx_nchar, rx_fct} = VEC[i][6:1];
            @(negedge clk);
            clear_ev();
            if (VEC[i][6]) tag = "R9";
            else if (ph <= 2) tag = "R7";
            else if (ph == 3) tag = "R8";
            else tag = "R9";
            if (VEC[i][0]) chk(tag, $sformatf("vec%0d drop", i), drop_state(), 1);
            else begin
                chk(tag, $sformatf("vec%0d rx_en", i), rx_en, 1);
                chk(tag, $sformatf("vec%0d tx_mode", i), tx_mode, mode_of(ph));
            end
        end

        // R3 idle waits for link_en
        goto(1, 0);
        repeat (50) @(negedge clk);
        chk("R3", "idle without link_en", tx_mode, 0);
        link_en = 1; @(negedge clk);
        chk("R3", "announce after link_en", tx_mode, 1);

        // R4 NULL alone does not complete; earlier NULL plus sent does
        goto(2, 0);
        rx_null = 1; @(negedge clk); rx_null = 0;
        chk("R4", "NULL without sent", tx_mode, 1);
        goto(2, 1);
        tx_null_done = 1; @(negedge clk); tx_null_done = 0;
        chk("R4", "recorded NULL plus sent", tx_mode, 2);
        chk("R6", "link_up in handshake", link_up, 0);

        // R5 announce timeout
        goto(2, 0); n = 0;
        do begin @(negedge clk); n++; end while (rx_en && n < 200);
        chk("R5", "announce timeout cycles", n, LONG);
        n = 0;
        do begin @(negedge clk); n++; end while (!rx_en && n < 200);
        chk("R12", "quiet after timeout", n, SHORT);

        // R6 handshake timeout and run entry
        goto(3, 0); n = 0;
        do begin @(negedge clk); n++; end while (rx_en && n < 200);
        chk("R6", "handshake timeout cycles", n, LONG);
        goto(4, 0);
        chk("R6", "link_up in active", link_up, 1);
        chk("R6", "tx_mode in active", tx_mode, 3);

        // R9 link_en drop in active
        link_en = 0; @(negedge clk);
        chk("R9", "link_en low drops", drop_state(), 1);

        // R10 fault beats FCT
        goto(3, 0);
        rx_fct = 1; rx_par_err = 1; @(negedge clk); clear_ev();
        chk("R10", "fault with fct", drop_state(), 1);
        chk("R10", "no link_up", link_up, 0);

        // R10 handshake completion on the timeout cycle
        goto(2, 0);
        repeat (LONG - 1) @(negedge clk);
        rx_null = 1; tx_null_done = 1; @(negedge clk); clear_ev();
        chk("R10", "progress at timeout", tx_mode, 2);

        // R11 NULL record forgotten after restart
        goto(0, 1);
        rx_disc = 1; @(negedge clk); rx_disc = 0;
        chk("R11", "disc drop", drop_state(), 1);
        repeat (SHORT) @(negedge clk);
        chk("R11", "back in recovery", rx_en, 1);
        rx_par_err = 1; @(negedge clk); rx_par_err = 0;
        chk("R11", "parity ignored after restart", rx_en, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule